// File: doc/BRIEF.md
# Hazard stall and flush controller

This block is the interlock logic for the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It compares the two source register indices of the instruction now in decode with the destination indices of the older instructions in execute, memory and writeback. Each comparison counts only when that stage will really write a register. From these matches it decides whether decode must wait.

A wait is carried out in three coordinated parts. The program counter is frozen, so the instruction being fetched stays put. The fetch/decode pipeline register is frozen, so the decode instruction stays put. A bubble, a canonical nop with every write enable cleared, is inserted into the decode/execute register, so nothing is duplicated downstream.

A taken branch or jump resolved in execute overrides a wait. It clears the fetch/decode register and bubbles the decode instruction, which removes both wrong-path instructions, and lets the program counter load the target.

One input picks between two pipeline styles. In full-interlock style there is no operand forwarding, so any pending write to a source register causes a wait. In load-use style forwarding exists, so only a load in execute whose destination is read by the decode instruction causes a wait. A parameter declares whether the register file writes before it reads in the same cycle. When it does, the writeback comparison is dropped.

Top module: `hazard_ctl`

## Requirements
- R1: With no taken branch and no hazard, the outputs are pc_we=1, ifid_we=1, ifid_flush=0, idex_bubble=0.
- R2: In full-interlock mode (fwd_mode=0), a nonzero id_src_a equal to ex_dst with ex_wr_en=1, or equal to mem_dst with mem_wr_en=1, gives a stall: pc_we=0, ifid_we=0, idex_bubble=1, ifid_flush=0.
- R3: The same stall rule as R2 applies to id_src_b.
- R4: A source index of 0 never causes a stall, even when it matches a destination of 0 that has its write enable set.
- R5: A destination whose stage write enable is 0 (stores, branches, bubbles) never causes a stall.
- R6: In full-interlock mode, a source that matches only wb_dst with wb_wr_en=1 causes a stall when RF_WBR=0 and no stall when RF_WBR=1.
- R7: In load-use mode (fwd_mode=1), a stall happens only when ex_wr_en=1, ex_is_load=1 and a nonzero source equals ex_dst. Matches in memory or writeback, and matches on non-load instructions in execute, do not stall.
- R8: ex_br_taken=1 gives pc_we=1, ifid_we=1, ifid_flush=1, idex_bubble=1, whatever the hazard inputs are.
- R9: In a pipeline driven by these controls with RF_WBR=1, an instruction that depends on the one right before it waits 2 cycles in full-interlock mode and 0 in load-use mode. An instruction that uses a load's result right after the load waits 1 cycle in load-use mode. A taken branch removes exactly the 2 instructions that follow it and causes no wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_mode | input | 1 | 0 = full interlock, 1 = stall only on load-use |
| id_src_a | input | AW | First source register index of the decode instruction |
| id_src_b | input | AW | Second source register index of the decode instruction |
| ex_dst | input | AW | Destination index of the instruction in execute |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a memory load |
| mem_dst | input | AW | Destination index of the instruction in memory |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | AW | Destination index of the instruction in writeback |
| wb_wr_en | input | 1 | Writeback instruction writes a register |
| ex_br_taken | input | 1 | Branch or jump in execute is taken |
| pc_we | output | 1 | Program counter may update |
| ifid_we | output | 1 | Fetch/decode register may load |
| ifid_flush | output | 1 | Fetch/decode register loads a nop |
| idex_bubble | output | 1 | Decode/execute register loads a nop instead of the decode instruction |

## Verification
All four controls are combinational, so each is due in the same cycle as the pipeline-register contents that cause it. The bench sets the inputs one nanosecond after a rising edge and samples at the following falling edge. The stall counts in R9 build up one cycle per rising edge. A behavioural pipeline model in the bench moves its instructions on each edge using the controls it expects, counts the wait cycles and the removed instructions, and checks both totals once the program has drained.

// File: rtl/hazard_ctl_pkg.sv
package hazard_ctl_pkg;

    // Stage slots in the destination vector; the decider relies on this order.
    localparam int STG_EX  = 0;
    localparam int STG_MEM = 1;
    localparam int STG_WB  = 2;
    localparam int NUM_STG = 3;

    typedef enum logic {
        MODE_INTERLOCK = 1'b0,
        MODE_LOADUSE   = 1'b1
    } hz_mode_e;

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic ifid_flush;
        logic idex_bubble;
    } hz_ctrl_t;

    localparam hz_ctrl_t CTRL_RUN   = '{pc_we: 1'b1, ifid_we: 1'b1, ifid_flush: 1'b0, idex_bubble: 1'b0};
    localparam hz_ctrl_t CTRL_HOLD  = '{pc_we: 1'b0, ifid_we: 1'b0, ifid_flush: 1'b0, idex_bubble: 1'b1};
    localparam hz_ctrl_t CTRL_SQUASH = '{pc_we: 1'b1, ifid_we: 1'b1, ifid_flush: 1'b1, idex_bubble: 1'b1};

    // A redirect wins over a hold: the held instruction is on the wrong path.
    function automatic hz_ctrl_t pick_ctrl(input logic redirect, input logic hold);
        if (redirect)  return CTRL_SQUASH;
        else if (hold) return CTRL_HOLD;
        else           return CTRL_RUN;
    endfunction

endpackage

// File: rtl/hazard_ctl_srcmatch.sv
module hazard_ctl_srcmatch #(
    parameter int AW   = 5,
    parameter int NSTG = 3
) (
    input  logic [AW-1:0]            src,
    input  logic [NSTG-1:0][AW-1:0]  dst,
    input  logic [NSTG-1:0]          dst_we,
    output logic [NSTG-1:0]          hit
);
    logic src_live;
    assign src_live = |src;

    for (genvar s = 0; s < NSTG; s++) begin : g_stg
        assign hit[s] = src_live && dst_we[s] && (dst[s] == src);
    end
endmodule

// File: rtl/hazard_ctl_decide.sv
module hazard_ctl_decide
    import hazard_ctl_pkg::*;
#(
    parameter bit RF_WBR = 1'b1
) (
    input  hz_mode_e             mode,
    input  logic [NUM_STG-1:0]   stg_hit,
    input  logic                 ex_load,
    output logic                 stall
);
    localparam logic WB_VISIBLE = !RF_WBR;

    logic wb_term;
    assign wb_term = stg_hit[STG_WB] & WB_VISIBLE;

    always_comb begin
        case (mode)
            MODE_INTERLOCK: stall = stg_hit[STG_EX] | stg_hit[STG_MEM] | wb_term;
            default:        stall = stg_hit[STG_EX] & ex_load;
        endcase
    end
endmodule

// File: rtl/hazard_ctl_resolve.sv
module hazard_ctl_resolve
    import hazard_ctl_pkg::*;
(
    input  logic     stall,
    input  logic     redirect,
    output hz_ctrl_t ctrl
);
    assign ctrl = pick_ctrl(redirect, stall);
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
    import hazard_ctl_pkg::*;
#(
    parameter int AW     = 5,
    parameter bit RF_WBR = 1'b1
) (
    input  logic          fwd_mode,
    input  logic [AW-1:0] id_src_a,
    input  logic [AW-1:0] id_src_b,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_wr_en,
    input  logic          ex_is_load,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wr_en,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wr_en,
    input  logic          ex_br_taken,
    output logic          pc_we,
    output logic          ifid_we,
    output logic          ifid_flush,
    output logic          idex_bubble
);
    localparam int NSRC = 2;

    logic [NUM_STG-1:0][AW-1:0]  dst;
    logic [NUM_STG-1:0]          dst_we;
    logic [NSRC-1:0][AW-1:0]     srcs;
    logic [NSRC-1:0][NUM_STG-1:0] hit_per_src;
    logic [NUM_STG-1:0]          stg_hit;
    logic                        stall;
    hz_mode_e                    mode;
    hz_ctrl_t                    ctrl;

    assign dst[STG_EX]     = ex_dst;
    assign dst[STG_MEM]    = mem_dst;
    assign dst[STG_WB]     = wb_dst;
    assign dst_we[STG_EX]  = ex_wr_en;
    assign dst_we[STG_MEM] = mem_wr_en;
    assign dst_we[STG_WB]  = wb_wr_en;
    assign srcs            = {id_src_b, id_src_a};
    assign mode            = hz_mode_e'(fwd_mode);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        hazard_ctl_srcmatch #(.AW(AW), .NSTG(NUM_STG)) u_match (
            .src    (srcs[i]),
            .dst    (dst),
            .dst_we (dst_we),
            .hit    (hit_per_src[i])
        );
    end

    always_comb begin
        stg_hit = '0;
        for (int i = 0; i < NSRC; i++) stg_hit |= hit_per_src[i];
    end

    hazard_ctl_decide #(.RF_WBR(RF_WBR)) u_decide (
        .mode    (mode),
        .stg_hit (stg_hit),
        .ex_load (ex_is_load),
        .stall   (stall)
    );

    hazard_ctl_resolve u_resolve (
        .stall    (stall),
        .redirect (ex_br_taken),
        .ctrl     (ctrl)
    );

    assign pc_we       = ctrl.pc_we;
    assign ifid_we     = ctrl.ifid_we;
    assign ifid_flush  = ctrl.ifid_flush;
    assign idex_bubble = ctrl.idex_bubble;
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
    parameter int AW = 5
) (
    input logic          fwd_mode,
    input logic [AW-1:0] id_src_a,
    input logic [AW-1:0] id_src_b,
    input logic          ex_wr_en,
    input logic          ex_is_load,
    input logic          mem_wr_en,
    input logic          wb_wr_en,
    input logic          ex_br_taken,
    input logic          pc_we,
    input logic          ifid_we,
    input logic          ifid_flush,
    input logic          idex_bubble
);
    always_comb begin
        // R2: a frozen PC comes with a frozen IF/ID and a bubble, never a flush
        a_r2_hold_is_complete: assert (pc_we || (!ifid_we && idex_bubble && !ifid_flush))
            else $error("hold controls inconsistent");
        // R4: zero sources never hold
        a_r4_zero_src_free: assert (ex_br_taken || id_src_a != '0 || id_src_b != '0 || (pc_we && !idex_bubble))
            else $error("zero source caused a hold");
        // R5: no writer anywhere means no hold
        a_r5_no_writer_free: assert (ex_br_taken || ex_wr_en || mem_wr_en || wb_wr_en || (pc_we && !idex_bubble))
            else $error("hold without any writer");
        // R7: load-use mode holds only behind a load in execute
        a_r7_loaduse_only: assert (!fwd_mode || ex_br_taken || (ex_wr_en && ex_is_load) || (pc_we && !idex_bubble))
            else $error("load-use mode held without a load");
        // R8: a taken branch squashes both younger slots and redirects
        a_r8_branch_squash: assert (!ex_br_taken || (pc_we && ifid_we && ifid_flush && idex_bubble))
            else $error("taken branch not squashed");
        // R8: a flush only comes from a taken branch
        a_r8_flush_source: assert (!ifid_flush || ex_br_taken)
            else $error("flush without a branch");
    end
endmodule

bind hazard_ctl hazard_ctl_chk #(.AW(AW)) u_chk (
    .fwd_mode    (fwd_mode),
    .id_src_a    (id_src_a),
    .id_src_b    (id_src_b),
    .ex_wr_en    (ex_wr_en),
    .ex_is_load  (ex_is_load),
    .mem_wr_en   (mem_wr_en),
    .wb_wr_en    (wb_wr_en),
    .ex_br_taken (ex_br_taken),
    .pc_we       (pc_we),
    .ifid_we     (ifid_we),
    .ifid_flush  (ifid_flush),
    .idex_bubble (idex_bubble)
);

// File: tb/hazard_ctl_tb_top.sv
`timescale 1ns/1ps
module hazard_ctl_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic       mode;
    logic [4:0] ra, rb, exrd, memrd, wbrd;
    logic       exwe, exld, memwe, wbwe, tk;
    logic [3:0] o_a, o_w;

    int checks = 0;
    int errors = 0;

    hazard_ctl #(.AW(5), .RF_WBR(1'b1)) dut_i (
        .fwd_mode(mode), .id_src_a(ra), .id_src_b(rb),
        .ex_dst(exrd), .ex_wr_en(exwe), .ex_is_load(exld),
        .mem_dst(memrd), .mem_wr_en(memwe), .wb_dst(wbrd), .wb_wr_en(wbwe),
        .ex_br_taken(tk),
        .pc_we(o_a[3]), .ifid_we(o_a[2]), .ifid_flush(o_a[1]), .idex_bubble(o_a[0])
    );

    hazard_ctl #(.AW(5), .RF_WBR(1'b0)) dut_nowbr_i (
        .fwd_mode(mode), .id_src_a(ra), .id_src_b(rb),
        .ex_dst(exrd), .ex_wr_en(exwe), .ex_is_load(exld),
        .mem_dst(memrd), .mem_wr_en(memwe), .wb_dst(wbrd), .wb_wr_en(wbwe),
        .ex_br_taken(tk),
        .pc_we(o_w[3]), .ifid_we(o_w[2]), .ifid_flush(o_w[1]), .idex_bubble(o_w[0])
    );

    // Expected controls {pc_we, ifid_we, ifid_flush, idex_bubble} from the requirements.
    function automatic logic [3:0] ref_ctrl(input logic wbr);
        bit reads_ex, reads_mem, reads_wb, hold;
        reads_ex  = exwe  && exrd  != 0 && (exrd  == ra || exrd  == rb);
        reads_mem = memwe && memrd != 0 && (memrd == ra || memrd == rb);
        reads_wb  = wbwe  && wbrd  != 0 && (wbrd  == ra || wbrd  == rb);
        if (mode) hold = reads_ex && exld;
        else      hold = reads_ex || reads_mem || (!wbr && reads_wb);
        if (tk)        return 4'b1111;
        else if (hold) return 4'b0001;
        else           return 4'b1100;
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic clear_inputs();
        mode = 0; ra = 0; rb = 0; exrd = 0; memrd = 0; wbrd = 0;
        exwe = 0; exld = 0; memwe = 0; wbwe = 0; tk = 0;
    endtask

    // Outputs are combinational: due at the falling edge of the cycle the inputs were set in.
    task automatic sample(input string tag);
        @(negedge clk);
        check(o_a, ref_ctrl(1'b1), {tag, " wbr"});
        check(o_w, ref_ctrl(1'b0), {tag, " nowbr"});
        @(posedge clk); #1;
    endtask

    typedef struct {
        bit v; bit we; bit ld; bit br;
        int rd; int ra; int rb; int tgt;
    } ins_t;

    ins_t prog[$];

    function automatic ins_t mk(int rd, int a, int b, bit we, bit ld, bit br, int tgt);
        ins_t x;
        x.v = 1; x.we = we; x.ld = ld; x.br = br;
        x.rd = rd; x.ra = a; x.rb = b; x.tgt = tgt;
        return x;
    endfunction

    function automatic ins_t nop();
        ins_t x;
        x.v = 0; x.we = 0; x.ld = 0; x.br = 0;
        x.rd = 0; x.ra = 0; x.rb = 0; x.tgt = 0;
        return x;
    endfunction

    // R9: behavioural pipeline that moves on each edge using the expected controls.
    task automatic run_prog(input bit m, input int exp_stall, input int exp_zap, input string tag);
        ins_t ifid, idex, exmem, memwb, old_ex;
        int pc, stalls, zapped;
        logic [3:0] e;
        ifid = nop(); idex = nop(); exmem = nop(); memwb = nop();
        pc = 0; stalls = 0; zapped = 0;
        for (int cyc = 0; cyc < 30; cyc++) begin
            mode  = m;
            ra    = 5'(ifid.ra);   rb    = 5'(ifid.rb);
            exrd  = 5'(idex.rd);   exwe  = idex.v & idex.we; exld = idex.v & idex.ld;
            tk    = idex.v & idex.br;
            memrd = 5'(exmem.rd);  memwe = exmem.v & exmem.we;
            wbrd  = 5'(memwb.rd);  wbwe  = memwb.v & memwb.we;
            @(negedge clk);
            e = ref_ctrl(1'b1);
            check(o_a, e, {tag, " step"});
            check(o_w, ref_ctrl(1'b0), {tag, " step nowbr"});
            old_ex = idex;
            memwb = exmem;
            exmem = old_ex;
            if (e[1]) begin
                zapped += int'(ifid.v) + ((pc < prog.size()) ? 1 : 0);
                idex = nop(); ifid = nop();
                pc = old_ex.tgt;
            end else if (!e[3]) begin
                stalls++;
                idex = nop();
            end else begin
                idex = ifid;
                if (pc < prog.size()) begin ifid = prog[pc]; pc++; end
                else ifid = nop();
            end
            @(posedge clk); #1;
        end
        check(stalls, exp_stall, {tag, " stall cycles"});
        check(zapped, exp_zap, {tag, " squashed count"});
        clear_inputs();
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_inputs();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(posedge clk); #1;

        // R1: idle
        clear_inputs(); sample("R1 idle");
        clear_inputs(); ra = 7; rb = 9; exrd = 4; exwe = 1; memrd = 5; memwe = 1; sample("R1 no match");
        // R2: source A against EX and MEM
        clear_inputs(); ra = 3; exrd = 3; exwe = 1; sample("R2 ex");
        clear_inputs(); ra = 3; memrd = 3; memwe = 1; sample("R2 mem");
        // R3: source B
        clear_inputs(); rb = 5; exrd = 5; exwe = 1; sample("R3 ex");
        clear_inputs(); rb = 5; memrd = 5; memwe = 1; sample("R3 mem");
        // R4: register zero
        clear_inputs(); exwe = 1; memwe = 1; wbwe = 1; sample("R4 zero");
        // R5: write enables clear
        clear_inputs(); ra = 3; rb = 6; exrd = 3; memrd = 6; wbrd = 3; sample("R5 no we");
        // R6: writeback match differs by parameter
        clear_inputs(); ra = 8; wbrd = 8; wbwe = 1; sample("R6 wb");
        clear_inputs(); rb = 8; wbrd = 8; wbwe = 1; sample("R6 wb b");
        // R7: load-use mode
        clear_inputs(); mode = 1; ra = 3; exrd = 3; exwe = 1; sample("R7 alu ex");
        clear_inputs(); mode = 1; ra = 3; exrd = 3; exwe = 1; exld = 1; sample("R7 load ex");
        clear_inputs(); mode = 1; rb = 3; memrd = 3; memwe = 1; wbrd = 3; wbwe = 1; sample("R7 mem wb");
        clear_inputs(); mode = 1; ra = 3; exrd = 3; exld = 1; sample("R7 load no we");
        // R8: branch overrides
        clear_inputs(); tk = 1; sample("R8 alone");
        clear_inputs(); tk = 1; ra = 3; exrd = 3; exwe = 1; exld = 1; sample("R8 over stall");

        // mixed patterns compared on every cycle
        for (int n = 0; n < 400; n++) begin
            mode = 1'($urandom); tk = (($urandom % 8) == 0);
            ra = 5'($urandom % 4); rb = 5'($urandom % 4);
            exrd = 5'($urandom % 4); memrd = 5'($urandom % 4); wbrd = 5'($urandom % 4);
            exwe = 1'($urandom); exld = 1'($urandom); memwe = 1'($urandom); wbwe = 1'($urandom);
            sample("R2 R3 R6 R7 mix");
        end
        clear_inputs();

        // R9 program runs
        prog = {};
        prog.push_back(mk(3, 1, 2, 1, 0, 0, 0));
        prog.push_back(mk(5, 3, 4, 1, 0, 0, 0));
        run_prog(1'b0, 2, 0, "R9 add-use interlock");
        run_prog(1'b1, 0, 0, "R9 add-use loaduse");
        prog = {};
        prog.push_back(mk(4, 8, 0, 1, 1, 0, 0));
        prog.push_back(mk(6, 4, 1, 1, 0, 0, 0));
        run_prog(1'b1, 1, 0, "R9 load-use");
        prog = {};
        prog.push_back(mk(0, 1, 2, 0, 0, 1, 3));
        prog.push_back(mk(3, 0, 3, 1, 0, 0, 0));
        prog.push_back(mk(5, 4, 6, 1, 0, 0, 0));
        prog.push_back(mk(3, 2, 4, 1, 0, 0, 0));
        run_prog(1'b1, 0, 2, "R9 branch");
        run_prog(1'b0, 0, 2, "R9 branch interlock");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule